// File: doc/BRIEF.md
# Calorimeter Jet Element Input Conditioner

This block receives parallel words from link deserialisers for paired electromagnetic (em) and hadronic (had) calorimeter channels. It turns each pair into one summed jet element. The block runs on a clock at twice the bunch rate and captures every channel on both edges of a bunch tick. A per-channel select bit chooses which of the two captures is trusted. The chosen word passes through a delay line of zero to three ticks, which lines up channels whose upstream paths differ in latency.

After the delay, each channel is qualified. A word that fails odd parity, carries the deserialiser's link-error flag, or belongs to a masked channel counts as zero energy. The em and had energies of a pair are then added with saturation. The 10-bit result leaves on five lines per pair at double rate, with the low half in the first half of the tick. An output flag marks which half is on the lines.

Top module: `jet_elem_conditioner`

## Requirements
- R1: While reset is asserted and at the first edge after its release, every jet element line and the low-half flag are 0.
- R2: An input word holds energy on bits 9:1 (1 GeV per count) and an odd parity bit on bit 0. A word whose ten bits hold an even number of ones gives zero energy.
- R3: Internal tick boundaries fall on every second clock edge, starting with the first edge after reset. Each channel is captured at the first and at the second edge of every tick. A select bit of 0 uses the first capture and 1 uses the second. The link-error flag is taken from the same capture as the word.
- R4: With a delay setting of d (0 to 3, two bits per channel), the low half of the result built from the words captured in tick k is driven after the first edge of tick k+2+d.
- R5: A set mask bit forces that channel's energy to zero, whatever the word holds.
- R6: A link-error flag set in the chosen capture forces that channel's energy to zero.
- R7: The jet element is the em energy plus the had energy, with an LSB of 1 GeV.
- R8: If either qualified energy is 511, or the sum does not fit in 10 bits, the jet element is 1023. A channel that is zeroed does not cause saturation.
- R9: A pair's jet element bits 4:0 are on its five lines for the clock cycle after a tick edge, and bits 9:5 for the cycle after that. The low-half flag is 1 while the low half is present, so it alternates every cycle.
- R10: Configuration vectors are indexed by channel: em of pair p is channel p, had of pair p is channel N_PAIRS+p. Word, link-error and output lines of pair p sit at slice p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bunch rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| em_words_i | input | N_PAIRS*10 | em channel words, energy on 9:1, odd parity on 0 |
| had_words_i | input | N_PAIRS*10 | had channel words, same format |
| em_lerr_i | input | N_PAIRS | em link-error flags |
| had_lerr_i | input | N_PAIRS | had link-error flags |
| cfg_late_i | input | 2*N_PAIRS | Per-channel capture select (1 = second capture) |
| cfg_dly_i | input | 2*N_PAIRS*2 | Per-channel delay in ticks, 2 bits each |
| cfg_mask_i | input | 2*N_PAIRS | Per-channel mask |
| je_lines_o | output | N_PAIRS*5 | Double-rate jet element lines |
| je_low_half_o | output | 1 | High while the low half is on the lines |

## Verification
The bound checker watches the following on every cycle:
- The low-half flag alternates.
- The low half leaving each pair matches the adder result of the preceding tick edge.
- A masked channel's qualified energy is zero.
- A 511 energy always yields 1023.
- The sum never drops below either addend, so it cannot wrap.

Only the bench scenarios can show the following:
- The right capture is chosen.
- Each delay setting lands at the stated tick.
- Parity and link errors zero the correct tick.
- The arithmetic is right across a full sweep of em energies.

// File: rtl/jec_pkg.sv
package jec_pkg;
  localparam int unsigned E_W = 9;          // energy bits per channel
  localparam int unsigned W_W = E_W + 1;    // word bits incl. parity
  localparam int unsigned J_W = E_W + 1;    // jet element bits
  localparam int unsigned H_W = J_W / 2;    // lines per pair
endpackage

// File: rtl/jec_chan_front.sv
module jec_chan_front
  import jec_pkg::*;
#(
  parameter int unsigned MAX_DLY = 3,
  localparam int unsigned DSW = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_a_en,
  input  logic           cap_b_en,
  input  logic [W_W-1:0] word_i,
  input  logic           lerr_i,
  input  logic           late_i,
  input  logic [DSW-1:0] dly_i,
  input  logic           mask_i,
  output logic [E_W-1:0] nrg_o
);
  typedef logic [W_W:0] tword_t;  // {lerr, word}

  tword_t cap_a_q, cap_a_d, cap_b_q, cap_b_d;
  tword_t line_q [MAX_DLY+1];
  tword_t line_d [MAX_DLY+1];
  tword_t tap;
  logic   good;

  always_comb begin
    cap_a_d = cap_a_en ? {lerr_i, word_i} : cap_a_q;
    cap_b_d = cap_b_en ? {lerr_i, word_i} : cap_b_q;
    line_d[0] = cap_a_en ? (late_i ? cap_b_q : cap_a_q) : line_q[0];
    for (int i = 1; i <= int'(MAX_DLY); i++)
      line_d[i] = cap_a_en ? line_q[i-1] : line_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
      for (int i = 0; i <= int'(MAX_DLY); i++) line_q[i] <= '0;
    end else begin
      cap_a_q <= cap_a_d;
      cap_b_q <= cap_b_d;
      for (int i = 0; i <= int'(MAX_DLY); i++) line_q[i] <= line_d[i];
    end
  end

  always_comb begin
    tap = line_q[0];
    for (int i = 1; i <= int'(MAX_DLY); i++)
      if (dly_i == DSW'(i)) tap = line_q[i];
    good  = (^tap[W_W-1:0]) & ~tap[W_W] & ~mask_i;
    nrg_o = good ? tap[W_W-1:1] : '0;
  end
endmodule

// File: rtl/jec_pair_add.sv
module jec_pair_add
  import jec_pkg::*;
(
  input  logic [E_W-1:0] em_i,
  input  logic [E_W-1:0] had_i,
  output logic [J_W-1:0] je_o
);
  logic [J_W:0] sum;
  logic         sat;

  always_comb begin
    sum  = (J_W+1)'(em_i) + (J_W+1)'(had_i);
    sat  = (&em_i) | (&had_i) | sum[J_W];
    je_o = sat ? '1 : sum[J_W-1:0];
  end
endmodule

// File: rtl/jec_ddr_mux.sv
module jec_ddr_mux
  import jec_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [J_W-1:0] je_i,
  output logic [H_W-1:0] lines_o
);
  logic [J_W-H_W-1:0] hi_q, hi_d;
  logic [H_W-1:0]     out_q, out_d;

  always_comb begin
    if (load_i) begin
      out_d = je_i[H_W-1:0];
      hi_d  = je_i[J_W-1:H_W];
    end else begin
      out_d = hi_q;
      hi_d  = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      hi_q  <= '0;
    end else begin
      out_q <= out_d;
      hi_q  <= hi_d;
    end
  end

  assign lines_o = out_q;
endmodule

// File: rtl/jet_elem_conditioner.sv
module jet_elem_conditioner
  import jec_pkg::*;
#(
  parameter int unsigned N_PAIRS = 2,
  parameter int unsigned MAX_DLY = 3,
  localparam int unsigned N_CH = 2 * N_PAIRS,
  localparam int unsigned DSW  = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PAIRS*W_W-1:0]   em_words_i,
  input  logic [N_PAIRS*W_W-1:0]   had_words_i,
  input  logic [N_PAIRS-1:0]       em_lerr_i,
  input  logic [N_PAIRS-1:0]       had_lerr_i,
  input  logic [N_CH-1:0]          cfg_late_i,
  input  logic [N_CH*DSW-1:0]      cfg_dly_i,
  input  logic [N_CH-1:0]          cfg_mask_i,
  output logic [N_PAIRS*H_W-1:0]   je_lines_o,
  output logic                     je_low_half_o
);
  logic ph_q, ph_d, tick;

  logic [N_PAIRS-1:0][E_W-1:0] nrg_em;
  logic [N_PAIRS-1:0][E_W-1:0] nrg_had;
  logic [N_PAIRS-1:0][J_W-1:0] je_sum;

  always_comb begin
    ph_d = ~ph_q;
    tick = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  for (genvar p = 0; p < int'(N_PAIRS); p++) begin : g_pair
    jec_chan_front #(.MAX_DLY(MAX_DLY)) i_em (
      .clk(clk), .rst_n(rst_n), .cap_a_en(tick), .cap_b_en(ph_q),
      .word_i(em_words_i[p*W_W +: W_W]), .lerr_i(em_lerr_i[p]),
      .late_i(cfg_late_i[p]), .dly_i(cfg_dly_i[p*DSW +: DSW]),
      .mask_i(cfg_mask_i[p]), .nrg_o(nrg_em[p])
    );
    jec_chan_front #(.MAX_DLY(MAX_DLY)) i_had (
      .clk(clk), .rst_n(rst_n), .cap_a_en(tick), .cap_b_en(ph_q),
      .word_i(had_words_i[p*W_W +: W_W]), .lerr_i(had_lerr_i[p]),
      .late_i(cfg_late_i[N_PAIRS+p]), .dly_i(cfg_dly_i[(N_PAIRS+p)*DSW +: DSW]),
      .mask_i(cfg_mask_i[N_PAIRS+p]), .nrg_o(nrg_had[p])
    );
    jec_pair_add i_add (
      .em_i(nrg_em[p]), .had_i(nrg_had[p]), .je_o(je_sum[p])
    );
    jec_ddr_mux i_mux (
      .clk(clk), .rst_n(rst_n), .load_i(tick), .je_i(je_sum[p]),
      .lines_o(je_lines_o[p*H_W +: H_W])
    );
  end

  assign je_low_half_o = ph_q;
endmodule

// File: rtl/jet_elem_conditioner_chk.sv
module jet_elem_conditioner_chk
  import jec_pkg::*;
#(
  parameter int unsigned N_PAIRS = 2,
  localparam int unsigned N_CH = 2 * N_PAIRS
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_CH-1:0]             cfg_mask_i,
  input logic                        low_half,
  input logic [N_PAIRS*H_W-1:0]      lines,
  input logic [N_PAIRS-1:0][E_W-1:0] nrg_em,
  input logic [N_PAIRS-1:0][E_W-1:0] nrg_had,
  input logic [N_PAIRS-1:0][J_W-1:0] je_sum
);
  assert_half_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (low_half != $past(low_half)));

  for (genvar p = 0; p < int'(N_PAIRS); p++) begin : g_chk
    assert_mask_em_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mask_i[p] |-> (nrg_em[p] == '0));
    assert_mask_had_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mask_i[N_PAIRS+p] |-> (nrg_had[p] == '0));
    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((&nrg_em[p]) || (&nrg_had[p])) |-> (&je_sum[p]));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (J_W'(nrg_em[p]) <= je_sum[p]) && (J_W'(nrg_had[p]) <= je_sum[p]));
    assert_low_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !low_half |=> (lines[p*H_W +: H_W] == $past(je_sum[p][H_W-1:0])));
  end
endmodule

bind jet_elem_conditioner jet_elem_conditioner_chk #(.N_PAIRS(N_PAIRS)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mask_i(cfg_mask_i),
  .low_half(je_low_half_o), .lines(je_lines_o),
  .nrg_em(nrg_em), .nrg_had(nrg_had), .je_sum(je_sum)
);

// File: tb/test_jet_elem_conditioner.sv
module test_jet_elem_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP*10-1:0] em_w, had_w;
  logic [NP-1:0] em_le, had_le;
  logic [3:0]    cfg_late, cfg_mask;
  logic [7:0]    cfg_dly;
  logic [NP*5-1:0] lines;
  logic          low_half;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int gt     = 0;

  logic [9:0] ha [4][16];
  logic [9:0] hb [4][16];
  logic       la [4][16];
  logic       lb [4][16];

  jet_elem_conditioner #(.N_PAIRS(NP)) i_jet_elem_conditioner (
    .clk(clk), .rst_n(rst_n), .em_words_i(em_w), .had_words_i(had_w),
    .em_lerr_i(em_le), .had_lerr_i(had_le), .cfg_late_i(cfg_late),
    .cfg_dly_i(cfg_dly), .cfg_mask_i(cfg_mask), .je_lines_o(lines),
    .je_low_half_o(low_half)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", tag, act, exp, gt);
    end
  endtask

  function automatic logic [9:0] mkw(int e, bit ok);
    logic [8:0] v = 9'(e);
    return {v, ok ? ~(^v) : (^v)};
  endfunction

  function automatic int nrg(int c, int t);
    int i = t & 15;
    logic [9:0] w = cfg_late[c] ? hb[c][i] : ha[c][i];
    logic le = cfg_late[c] ? lb[c][i] : la[c][i];
    if ((^w) == 1'b1 && !le && !cfg_mask[c]) return int'(w[9:1]);
    return 0;
  endfunction

  function automatic int exp_je(int p, int t);
    int em = nrg(p, t - 2 - int'(cfg_dly[p*2 +: 2]));
    int hd = nrg(2 + p, t - 2 - int'(cfg_dly[(2+p)*2 +: 2]));
    if (em == 511 || hd == 511 || em + hd > 1023) return 1023;
    return em + hd;
  endfunction

  // mode 0: counter ramp, 1: random with errors and saturation, 2: sweep
  task automatic gen(int mode, int k, bit second);
    for (int c = 0; c < 4; c++) begin
      int e; bit ok; bit le;
      ok = 1'b1; le = 1'b0;
      case (mode)
        0: e = second ? int'($urandom % 512) : (gt * 37 + c * 101) % 512;
        1: begin
             e  = ($urandom % 6 == 0) ? 511 : int'($urandom % 512);
             ok = ($urandom % 4) != 0;
             le = ($urandom % 4) == 0;
           end
        default: e = (c < 2) ? (k % 512) : ((k * 7 + 3 + c) % 512);
      endcase
      if (second) begin hb[c][gt & 15] = mkw(e, ok); lb[c][gt & 15] = le; end
      else        begin ha[c][gt & 15] = mkw(e, ok); la[c][gt & 15] = le; end
      if (c < 2) begin em_w[c*10 +: 10] = mkw(e, ok); em_le[c] = le; end
      else begin had_w[(c-2)*10 +: 10] = mkw(e, ok); had_le[c-2] = le; end
    end
  endtask

  task automatic run_scen(string tag, int n, int mode);
    int start = gt;
    bit hi_pend = 0;
    int hi_exp [NP];
    for (int k = 0; k < n; k++) begin
      // at negedge before the first edge of tick gt
      if (hi_pend) begin
        for (int p = 0; p < NP; p++)
          chk({tag, " R9 high half"}, int'(lines[p*5 +: 5]), hi_exp[p]);
        chk({tag, " R9 flag high-half"}, int'(low_half), 0);
      end
      gen(mode, k, 1'b0);
      @(negedge clk);
      hi_pend = (gt >= start + 6);
      if (hi_pend) begin
        for (int p = 0; p < NP; p++) begin
          int x = exp_je(p, gt);
          chk({tag, " low half"}, int'(lines[p*5 +: 5]), x & 31);
          hi_exp[p] = x >> 5;
        end
        chk({tag, " R9 flag low-half"}, int'(low_half), 1);
      end
      gen(mode, k, 1'b1);
      @(negedge clk);
      gt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    em_w = '0; had_w = '0; em_le = '0; had_le = '0;
    cfg_late = '0; cfg_mask = '0; cfg_dly = '0;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 16; i++) begin
        ha[c][i] = '0; hb[c][i] = '0; la[c][i] = 1'b0; lb[c][i] = 1'b0;
      end
    repeat (3) @(negedge clk);
    chk("R1 lines in reset", int'(lines), 0);
    chk("R1 flag in reset", int'(low_half), 0);
    rst_n = 1'b1;

    // R2 R3 R7 R9: first capture, no delay, ramp energies
    run_scen("R2 R3 R7 scen-first", 40, 0);
    // R3: second capture on every channel
    cfg_late = 4'b1111;
    run_scen("R3 scen-second", 40, 0);
    // R4 R10: mixed delays and captures per channel
    cfg_late = 4'b0101;
    cfg_dly  = {2'd0, 2'd1, 2'd2, 2'd3};
    run_scen("R4 R10 scen-delay", 60, 0);
    // R2 R6 R8: parity errors, link errors, saturation
    cfg_dly  = {2'd3, 2'd0, 2'd1, 2'd2};
    cfg_late = 4'b1010;
    run_scen("R2 R6 R8 scen-errors", 120, 1);
    // R5 R10: masks on em of pair 0 and had of pair 1
    cfg_mask = 4'b1001;
    run_scen("R5 R10 R8 scen-mask", 80, 1);
    // R7 R8: exhaustive em sweep with derived had values
    cfg_mask = 4'b0000;
    cfg_late = 4'b0000;
    cfg_dly  = 8'h00;
    run_scen("R7 R8 scen-sweep", 520, 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule